// File: doc/BRIEF.md
# Mispredict Fetch Stall Controller

This block governs the fetch PC register and the fetch enable of a pipelined front end. It works as if the outcome of every conditional branch is already known at fetch. When a fetched conditional branch turns out to be mispredicted, the block does not let fetch run down the wrong path. Instead it freezes fetch and remembers a tag for that one branch.

Fetch stays frozen until the execute stage reports that the remembered branch has resolved, and that report carries the correct target. One cycle after the report, the target is written into the PC register. Fetch resumes on the correct path in the cycle after that. The block does not wait for older instructions to retire.

The fetch and decode stage depths are parameters. Their sum is the shortest distance between a misprediction and its resolution. Two free-running counters report total cycles and the cycles lost to misprediction stalls.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: While and right after reset, `fetch_en` is 1, `fetch_pc` equals `RESET_PC`, and both counters are 0.
- R2: A fetch fires when `fe_valid` and `fetch_en` are both 1. A fire that does not start a stall moves `fetch_pc` on the next cycle. It becomes `fe_pred_target` if `fe_pred_taken` is 1, and `fetch_pc + INST_BYTES` otherwise.
- R3: A fire with `fe_br_kind` = 2'b01 (conditional) and `fe_mispred` = 1 drives `fetch_en` to 0 from the next cycle. `fetch_pc` holds its value during that time.
- R4: A fire with `fe_br_kind` of 2'b00 (no branch), 2'b10 (direct jump) or 2'b11 (indirect) never stalls, whatever `fe_mispred` holds.
- R5: While stalled, `fetch_en` stays 0 and `fetch_pc` is unchanged until `ex_res_valid` arrives with an `ex_res_tag` equal to the tag of the stalling branch. A resolution that carries any other tag is ignored.
- R6: Suppose a matching resolution arrives in cycle r. In cycle r+1, `fetch_en` is still 0. In cycle r+2, `fetch_en` is 1 and `fetch_pc` equals the `ex_res_pc` given in cycle r.
- R7: `cycle_count` goes up by one on every clock after reset.
- R8: `stall_count` goes up by one for each cycle in which `fetch_en` is 0, and holds otherwise. One misprediction resolved d cycles after it was fetched adds d+1.
- R9: When `fe_valid` is 0, `fetch_pc` does not change and no stall starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | Front end presents an instruction this cycle |
| fe_br_kind | input | 2 | Branch class: 00 none, 01 conditional, 10 jump, 11 indirect |
| fe_mispred | input | 1 | Prediction disagrees with the known outcome |
| fe_br_tag | input | TAG_W | Tag of the fetched branch |
| fe_pred_taken | input | 1 | Predictor steers to `fe_pred_target` |
| fe_pred_target | input | PC_W | Predicted next PC when taken |
| ex_res_valid | input | 1 | Execute stage resolves a branch |
| ex_res_tag | input | TAG_W | Tag of the resolved branch |
| ex_res_pc | input | PC_W | Correct next PC of the resolved branch |
| fetch_en | output | 1 | Fetch allowed this cycle |
| fetch_pc | output | PC_W | Current PC register |
| cycle_count | output | CNT_W | Cycles since reset |
| stall_count | output | CNT_W | Cycles with fetch frozen |

## Verification
The assertions take for granted that a resolution whose tag matches the stalling branch never comes sooner than FE_DEPTH+ID_DEPTH cycles after that branch was fetched. They also take for granted that reset is released away from the active clock edge. The stimulus keeps to both. It places each matching resolution at a distance swept upward from that minimum, and it releases reset on a falling edge. Resolutions with a wrong tag are sent early in the stall, and no assumption restricts their timing.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STALL = 2'd1,
    ST_REDIR = 2'd2
  } fsc_state_e;

  localparam logic [1:0] BK_NONE = 2'b00;
  localparam logic [1:0] BK_COND = 2'b01;
  localparam logic [1:0] BK_JUMP = 2'b10;
  localparam logic [1:0] BK_IND  = 2'b11;
endpackage

// File: rtl/fsc_tracker.sv
module fsc_tracker #(
  parameter int TAG_W   = 4,
  parameter int PC_W    = 32,
  parameter int MIN_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mp_start,
  input  logic [TAG_W-1:0] br_tag,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic [PC_W-1:0]  res_pc,
  output logic             run,
  output logic             waiting,
  output logic             redir_load,
  output logic [PC_W-1:0]  redir_pc,
  output logic [TAG_W-1:0] held_tag
);
  import fsc_pkg::*;

  localparam int AGE_W = $clog2(MIN_LAT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_LAT);

  fsc_state_e       state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic [PC_W-1:0]  rpc_q;
  logic [AGE_W-1:0] age_q, age_d;
  logic             tag_en, rpc_en, age_en;
  logic             match;

  assign match = res_valid && (res_tag == tag_q);

  always_comb begin
    state_d = state_q;
    tag_en  = 1'b0;
    rpc_en  = 1'b0;
    age_en  = 1'b0;
    age_d   = age_q;
    unique case (state_q)
      ST_RUN: begin
        if (mp_start) begin
          state_d = ST_STALL;
          tag_en  = 1'b1;
          age_en  = 1'b1;
          age_d   = AGE_W'(1);
        end
      end
      ST_STALL: begin
        if (age_q != AGE_MAX) begin
          age_en = 1'b1;
          age_d  = age_q + AGE_W'(1);
        end
        if (match) begin
          state_d = ST_REDIR;
          rpc_en  = 1'b1;
        end
      end
      ST_REDIR: state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      tag_q   <= '0;
      rpc_q   <= '0;
      age_q   <= '0;
    end else begin
      state_q <= state_d;
      if (tag_en) tag_q <= br_tag;
      if (rpc_en) rpc_q <= res_pc;
      if (age_en) age_q <= age_d;
    end
  end

  assign run        = (state_q == ST_RUN);
  assign waiting    = (state_q == ST_STALL);
  assign redir_load = (state_q == ST_REDIR);
  assign redir_pc   = rpc_q;
  assign held_tag   = tag_q;

  // R5
  min_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && match) |-> (age_q >= AGE_MAX));

  // R6
  redir_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_load |=> run);
endmodule

// File: rtl/fsc_pc_reg.sv
module fsc_pc_reg #(
  parameter int               PC_W       = 32,
  parameter int               INST_BYTES = 4,
  parameter logic [PC_W-1:0]  RESET_PC   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] pred_target,
  input  logic            redir_load,
  input  logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [PC_W-1:0] pc_q, pc_d, seq_pc;
  logic            pc_en;

  assign seq_pc = pc_q + STEP;

  always_comb begin
    pc_en = redir_load || advance;
    if (redir_load)      pc_d = redir_pc;
    else if (pred_taken) pc_d = pred_target;
    else                 pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R9
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !redir_load) |=> (pc == $past(pc)));
endmodule

// File: rtl/fsc_perf.sv
module fsc_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stalled,
  output logic [CNT_W-1:0] cycles,
  output logic [CNT_W-1:0] stalls
);
  localparam int NCNT = 2;

  logic [NCNT-1:0]            inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;

  assign inc = {stalled, 1'b1};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_d;
    assign cnt_d = cnt_q[g] + CNT_W'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (inc[g]) cnt_q[g] <= cnt_d;
    end
  end

  assign cycles = cnt_q[0];
  assign stalls = cnt_q[1];

  // R7
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cycles == CNT_W'($past(cycles) + CNT_W'(1))));
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl #(
  parameter int              PC_W       = 32,
  parameter int              TAG_W      = 4,
  parameter int              CNT_W      = 32,
  parameter int              INST_BYTES = 4,
  parameter int              FE_DEPTH   = 2,
  parameter int              ID_DEPTH   = 2,
  parameter logic [PC_W-1:0] RESET_PC   = PC_W'(32'h0000_0100)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fe_valid,
  input  logic [1:0]       fe_br_kind,
  input  logic             fe_mispred,
  input  logic [TAG_W-1:0] fe_br_tag,
  input  logic             fe_pred_taken,
  input  logic [PC_W-1:0]  fe_pred_target,
  input  logic             ex_res_valid,
  input  logic [TAG_W-1:0] ex_res_tag,
  input  logic [PC_W-1:0]  ex_res_pc,
  output logic             fetch_en,
  output logic [PC_W-1:0]  fetch_pc,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] stall_count
);
  import fsc_pkg::*;

  localparam int MIN_LAT = FE_DEPTH + ID_DEPTH;

  logic             fire, mp_start, advance;
  logic             run, waiting, redir_load;
  logic [PC_W-1:0]  redir_pc;
  logic [TAG_W-1:0] held_tag;

  assign fire     = fe_valid && run;
  assign mp_start = fire && (fe_br_kind == BK_COND) && fe_mispred;
  assign advance  = fire && !mp_start;
  assign fetch_en = run;

  fsc_tracker #(.TAG_W(TAG_W), .PC_W(PC_W), .MIN_LAT(MIN_LAT)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mp_start   (mp_start),
    .br_tag     (fe_br_tag),
    .res_valid  (ex_res_valid),
    .res_tag    (ex_res_tag),
    .res_pc     (ex_res_pc),
    .run        (run),
    .waiting    (waiting),
    .redir_load (redir_load),
    .redir_pc   (redir_pc),
    .held_tag   (held_tag)
  );

  fsc_pc_reg #(.PC_W(PC_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .pred_taken  (fe_pred_taken),
    .pred_target (fe_pred_target),
    .redir_load  (redir_load),
    .redir_pc    (redir_pc),
    .pc          (fetch_pc)
  );

  fsc_perf #(.CNT_W(CNT_W)) u_perf (
    .clk     (clk),
    .rst_n   (rst_n),
    .stalled (!run),
    .cycles  (cycle_count),
    .stalls  (stall_count)
  );

  // R2
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mp_start && !fe_pred_taken) |=>
      (fetch_pc == PC_W'($past(fetch_pc) + PC_W'(INST_BYTES))));

  // R3
  mp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mp_start |=> (!fetch_en && (fetch_pc == $past(fetch_pc))));

  // R4
  other_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (fe_br_kind != BK_COND)) |=> fetch_en);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !(ex_res_valid && (ex_res_tag == held_tag))) |=>
      (!fetch_en && $stable(fetch_pc)));

  // R6
  redir_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_load |=> (fetch_en && (fetch_pc == $past(redir_pc))));

  // R8
  stall_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> (stall_count == CNT_W'($past(stall_count) + CNT_W'(1))));

  // R8
  stall_hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> $stable(stall_count));
endmodule

// File: tb/fetch_stall_ctrl_bench.sv
module fetch_stall_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 32;
  localparam int TAG_W      = 4;
  localparam int CNT_W      = 32;
  localparam int STEP       = 4;
  localparam int FE_D       = 2;
  localparam int ID_D       = 2;
  localparam int MINL       = FE_D + ID_D;
  localparam logic [PC_W-1:0] RST_PC = 32'h0000_0100;

  logic             clk;
  logic             rst_n;
  logic             fe_valid;
  logic [1:0]       fe_br_kind;
  logic             fe_mispred;
  logic [TAG_W-1:0] fe_br_tag;
  logic             fe_pred_taken;
  logic [PC_W-1:0]  fe_pred_target;
  logic             ex_res_valid;
  logic [TAG_W-1:0] ex_res_tag;
  logic [PC_W-1:0]  ex_res_pc;
  logic             fetch_en;
  logic [PC_W-1:0]  fetch_pc;
  logic [CNT_W-1:0] cycle_count;
  logic [CNT_W-1:0] stall_count;

  int  n_tests, n_fail;
  bit  finished;
  logic [PC_W-1:0] exp_pc;
  longint exp_cyc, exp_stall;

  fetch_stall_ctrl #(
    .PC_W(PC_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .INST_BYTES(STEP),
    .FE_DEPTH(FE_D), .ID_DEPTH(ID_D), .RESET_PC(RST_PC)
  ) u_fetch_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_br_kind(fe_br_kind),
    .fe_mispred(fe_mispred), .fe_br_tag(fe_br_tag), .fe_pred_taken(fe_pred_taken),
    .fe_pred_target(fe_pred_target), .ex_res_valid(ex_res_valid),
    .ex_res_tag(ex_res_tag), .ex_res_pc(ex_res_pc), .fetch_en(fetch_en),
    .fetch_pc(fetch_pc), .cycle_count(cycle_count), .stall_count(stall_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    exp_cyc++;
  endtask

  task automatic idle_inputs();
    fe_valid = 1'b0; fe_br_kind = 2'b00; fe_mispred = 1'b0; fe_br_tag = '0;
    fe_pred_taken = 1'b0; fe_pred_target = '0;
    ex_res_valid = 1'b0; ex_res_tag = '0; ex_res_pc = '0;
  endtask

  task automatic check_counters();
    check(cycle_count == CNT_W'(exp_cyc), "R7 cycle_count", cycle_count, exp_cyc);
    check(stall_count == CNT_W'(exp_stall), "R8 stall_count", stall_count, exp_stall);
  endtask

  // One fire that must not stall (R2, R4)
  task automatic plain_fire(input logic [1:0] kind, input logic mp, input logic tk,
                            input logic [PC_W-1:0] tgt);
    fe_valid = 1'b1; fe_br_kind = kind; fe_mispred = mp;
    fe_pred_taken = tk; fe_pred_target = tgt;
    tick();
    idle_inputs();
    exp_pc = tk ? tgt : exp_pc + PC_W'(STEP);
    check(fetch_en == 1'b1, "R4 no stall for non-conditional or correct", fetch_en, 1);
    check(fetch_pc == exp_pc, "R2 next pc", fetch_pc, exp_pc);
  endtask

  // Mispredicted conditional, resolved d cycles after its fetch (R3, R5, R6, R8)
  task automatic mp_episode(input int d, input logic [TAG_W-1:0] tag,
                            input logic tk, input logic [PC_W-1:0] fix_pc);
    fe_valid = 1'b1; fe_br_kind = 2'b01; fe_mispred = 1'b1; fe_br_tag = tag;
    fe_pred_taken = tk; fe_pred_target = fix_pc ^ 32'h0000_0F00;
    tick();
    idle_inputs();
    fe_valid = 1'b1;
    check(fetch_en == 1'b0, "R3 fetch frozen", fetch_en, 0);
    check(fetch_pc == exp_pc, "R3 pc held", fetch_pc, exp_pc);
    for (int k = 1; k < d; k++) begin
      if (k == 1) begin
        ex_res_valid = 1'b1; ex_res_tag = tag ^ TAG_W'(1); ex_res_pc = fix_pc + 32'h40;
      end
      tick();
      ex_res_valid = 1'b0;
      check(fetch_en == 1'b0, "R5 stall holds", fetch_en, 0);
      check(fetch_pc == exp_pc, "R5 pc unchanged", fetch_pc, exp_pc);
    end
    ex_res_valid = 1'b1; ex_res_tag = tag; ex_res_pc = fix_pc;
    tick();
    ex_res_valid = 1'b0; ex_res_pc = '0;
    check(fetch_en == 1'b0, "R6 still frozen in r+1", fetch_en, 0);
    check(fetch_pc == exp_pc, "R6 pc not yet loaded in r+1", fetch_pc, exp_pc);
    fe_valid = 1'b0;
    tick();
    exp_pc = fix_pc;
    exp_stall += d + 1;
    check(fetch_en == 1'b1, "R6 fetch resumes in r+2", fetch_en, 1);
    check(fetch_pc == exp_pc, "R6 corrected pc", fetch_pc, exp_pc);
    check_counters();
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    exp_cyc = 0; exp_stall = 0; exp_pc = RST_PC;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(fetch_en == 1'b1, "R1 fetch_en in reset", fetch_en, 1);
    check(fetch_pc == RST_PC, "R1 reset pc", fetch_pc, RST_PC);
    check_counters();
    rst_n = 1'b1;
    check(fetch_pc == RST_PC, "R1 pc after release", fetch_pc, RST_PC);

    // R9: idle fetch with branch fields set
    fe_br_kind = 2'b01; fe_mispred = 1'b1; fe_pred_taken = 1'b1; fe_pred_target = 32'hDEAD_0000;
    tick();
    idle_inputs();
    check(fetch_pc == exp_pc, "R9 pc idle", fetch_pc, exp_pc);
    check(fetch_en == 1'b1, "R9 no stall when idle", fetch_en, 1);

    // Sweep kinds x mispredict flag x prediction direction
    for (int i = 0; i < 16; i++) begin
      logic [1:0] kind;
      logic mp, tk;
      logic [PC_W-1:0] tgt;
      kind = 2'(i >> 2);
      mp   = i[1];
      tk   = i[0];
      tgt  = 32'h0001_0000 + PC_W'(i * 32'h110);
      if (kind == 2'b01 && mp)
        mp_episode(MINL + (i % 4), TAG_W'(i), tk, tgt);
      else
        plain_fire(kind, mp, tk, tgt);
    end

    // Resolution distance sweep with cycling tags
    for (int d = MINL; d < MINL + 6; d++) begin
      mp_episode(d, TAG_W'(d * 3), 1'b0, 32'h0002_0000 + PC_W'(d * 8));
      plain_fire(2'b00, 1'b0, 1'b0, '0);
    end

    // Back-to-back mispredicts right after resume
    mp_episode(MINL, 4'hA, 1'b1, 32'h0003_0000);
    mp_episode(MINL, 4'hA, 1'b0, 32'h0003_1000);
    check_counters();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule